// File: doc/BRIEF.md
# SPI Frame Attribute Selector and Transfer Counter

This block does the frame bookkeeping for an SPI controller that can act as master or slave. It holds a bank of transfer-attribute words. The number of words is fixed at build time, between two and eight. At the start of each frame the block latches which word applies and drives that word out to the rest of the controller. In master mode the executing command's select field picks the word. In slave mode word 0 is always used.

The block also keeps a 16-bit transfer counter. The counter advances once for each finished frame. A command can clear it at frame start, and software can preset it. Software reaches both the counter and the attribute words through a simple 32-bit register port. Writes are only accepted while the controller is idle. A write attempted while the controller is running is dropped and sets a sticky error flag. Every port is a plain control or status pin, so there is no valid/ready handshake and no back-pressure.

Register map (4-bit address): address 0 is the counter register. Addresses 1 to N hold attribute words 0 to N-1. Any other address reads as zero and ignores writes.

Top module: `spi_frame_attr_unit`

## Requirements
- R1: After reset, every attribute word, the counter, the latched attribute index, `frame_attr` and `wr_err` are zero.
- R2: While `busy` is low, a write to address 1+k (k < N) stores the 32-bit data in attribute word k. Reading that address returns the stored word.
- R3: In master mode (`is_master`=1), a `frame_start` pulse with `cmd_sel` < N latches that index. From the next cycle, `frame_attr` equals attribute word `cmd_sel`.
- R4: In slave mode (`is_master`=0), a `frame_start` pulse latches index 0, whatever `cmd_sel` is.
- R5: In master mode, a `cmd_sel` value of N or above latches index 0.
- R6: While `busy` is high, writes to the counter or attribute addresses leave every register unchanged and set `wr_err`. `wr_err` then stays set until reset.
- R7: The counter register reads as the count in bits 31:16 with bits 15:0 always zero. Written data bits 15:0 are ignored.
- R8: A `last_bit` pulse increments the count by one on the next edge. Incrementing 65535 gives 0.
- R9: An accepted write to address 0 presets the count to data bits 31:16. A preset takes priority over the frame strobes in the same cycle and discards any deferred increment.
- R10: A `frame_start` pulse with `cmd_clr_cnt`=1 sets the count to zero. A `frame_start` pulse with `cmd_clr_cnt`=0 leaves the count unchanged.
- R11: When a clearing frame start and `last_bit` fall in the same cycle, the count becomes zero. The lost increment is added on the next `last_bit`, which therefore adds two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| busy | input | 1 | Controller running; software writes are refused |
| frame_start | input | 1 | One-cycle strobe at the start of a frame |
| last_bit | input | 1 | One-cycle strobe when a frame's last bit is sent |
| cmd_sel | input | 3 | Attribute select field of the executing command |
| cmd_clr_cnt | input | 1 | Clear-count flag of the executing command |
| reg_wr_en | input | 1 | Software write strobe |
| reg_addr | input | 4 | Software write address |
| reg_wr_data | input | 32 | Software write data |
| reg_rd_addr | input | 4 | Software read address |
| reg_rd_data | output | 32 | Read data, combinational from `reg_rd_addr` |
| frame_attr | output | 32 | Attribute word selected for the current frame |
| wr_err | output | 1 | Sticky flag for a write refused while busy |

## Verification
Every stored result appears one clock edge after its stimulus. Writes, counter steps, clears, presets, the attribute index latch and the error flag are all registered once. The read port is combinational from the read address and the stored state. The bench drives every input on the falling edge and lets one rising edge pass. It then samples on the following falling edge, a settling delay after setting the read address. The expected counts and selected words are computed in the bench from the written values.

// File: rtl/spi_attr_pkg.sv
package spi_attr_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 16;
  localparam int ADDR_W   = 4;
  localparam int SEL_W    = 3;
  localparam int MAX_ATTR = 8;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = '0;
  localparam logic [ADDR_W-1:0] ADDR_ATTR0 = ADDR_W'(1);
endpackage

// File: rtl/spi_attr_bank.sv
module spi_attr_bank
  import spi_attr_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(MAX_ATTR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [N-1:0][DATA_W-1:0] words
);
  for (genvar g = 0; g < N; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        words[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))
        words[g] <= wr_data;
    end
  end

  a_r6_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(words));
endmodule

// File: rtl/spi_attr_select.sv
module spi_attr_select
  import spi_attr_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(MAX_ATTR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic                     is_master,
  input  logic [SEL_W-1:0]         cmd_sel,
  input  logic [N-1:0][DATA_W-1:0] words,
  output logic [IDX_W-1:0]         cur_idx,
  output logic [DATA_W-1:0]        frame_attr
);
  logic [IDX_W-1:0] next_idx;

  always_comb begin
    if (!is_master || int'(cmd_sel) >= N)
      next_idx = '0;
    else
      next_idx = IDX_W'(cmd_sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur_idx <= '0;
    else if (frame_start)
      cur_idx <= next_idx;
  end

  always_comb begin
    frame_attr = '0;
    for (int k = 0; k < N; k++)
      if (cur_idx == IDX_W'(k))
        frame_attr = words[k];
  end

  a_r4_slave_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !is_master) |=> cur_idx == '0);
  a_r5_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && is_master && int'(cmd_sel) >= N) |=> cur_idx == '0);
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_idx) < N);
endmodule

// File: rtl/spi_xfer_counter.sv
module spi_xfer_counter
  import spi_attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             frame_start,
  input  logic             clr,
  input  logic             last_bit,
  output logic [CNT_W-1:0] cnt
);
  logic pend;
  logic do_clr;

  assign do_clr = frame_start && clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (wr_en) begin
      cnt  <= wr_val;
      pend <= 1'b0;
    end else if (do_clr) begin
      cnt  <= '0;
      pend <= last_bit;
    end else if (last_bit) begin
      cnt  <= cnt + CNT_W'(1) + CNT_W'(pend);
      pend <= 1'b0;
    end
  end

  a_r9_preset: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt == $past(wr_val));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (do_clr && !wr_en) |=> cnt == '0);
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && !do_clr && !wr_en) |=> cnt == $past(cnt) + CNT_W'(1) + CNT_W'($past(pend)));
  a_r11_defer: assert property (@(posedge clk) disable iff (!rst_n)
    (do_clr && last_bit && !wr_en) |=> pend);
endmodule

// File: rtl/spi_frame_attr_unit.sv
module spi_frame_attr_unit
  import spi_attr_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              busy,
  input  logic              frame_start,
  input  logic              last_bit,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic              cmd_clr_cnt,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic [DATA_W-1:0] frame_attr,
  output logic              wr_err
);
  localparam int IDX_W = $clog2(MAX_ATTR);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [N-1:0][DATA_W-1:0] words;
  logic [CNT_W-1:0]         cnt;
  logic [IDX_W-1:0]         cur_idx;
  logic                     hit_cnt, hit_attr, wr_ok;
  logic [IDX_W-1:0]         wr_idx;

  assign hit_cnt  = (reg_addr == ADDR_COUNT);
  assign hit_attr = (int'(reg_addr) >= int'(ADDR_ATTR0)) &&
                    (int'(reg_addr) < int'(ADDR_ATTR0) + N);
  assign wr_idx   = IDX_W'(reg_addr - ADDR_ATTR0);
  assign wr_ok    = reg_wr_en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)
      wr_err <= 1'b0;
    else if (reg_wr_en && busy && (hit_cnt || hit_attr))
      wr_err <= 1'b1;
  end

  spi_attr_bank #(.N(N), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ok && hit_attr), .wr_idx(wr_idx), .wr_data(reg_wr_data),
    .words(words)
  );

  spi_attr_select #(.N(N), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .is_master(is_master), .cmd_sel(cmd_sel),
    .words(words), .cur_idx(cur_idx), .frame_attr(frame_attr)
  );

  spi_xfer_counter u_cnt (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ok && hit_cnt), .wr_val(reg_wr_data[DATA_W-1:PAD_W]),
    .frame_start(frame_start), .clr(cmd_clr_cnt), .last_bit(last_bit),
    .cnt(cnt)
  );

  always_comb begin
    reg_rd_data = '0;
    if (reg_rd_addr == ADDR_COUNT)
      reg_rd_data = {cnt, {PAD_W{1'b0}}};
    else
      for (int k = 0; k < N; k++)
        if (reg_rd_addr == ADDR_W'(int'(ADDR_ATTR0) + k))
          reg_rd_data = words[k];
  end

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);
  a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && busy && hit_cnt) |=> wr_err);
  a_r6_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr_en && hit_cnt && !frame_start && !last_bit) |=> $stable(cnt));
  a_r7_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_addr == ADDR_COUNT) |-> reg_rd_data[PAD_W-1:0] == '0);
endmodule

// File: tb/spi_frame_attr_unit_test.sv
module spi_frame_attr_unit_test;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_master = 1'b0, busy = 1'b0, frame_start = 1'b0, last_bit = 1'b0;
  logic [2:0]  cmd_sel = '0;
  logic        cmd_clr_cnt = 1'b0, reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0, reg_rd_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data, frame_attr;
  logic        wr_err;

  int vectors = 0, errors = 0;
  logic [31:0] attr_val [N];
  logic [15:0] exp_cnt;

  always #10 clk = ~clk;

  spi_frame_attr_unit #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .busy(busy),
    .frame_start(frame_start), .last_bit(last_bit), .cmd_sel(cmd_sel),
    .cmd_clr_cnt(cmd_clr_cnt), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data), .frame_attr(frame_attr), .wr_err(wr_err)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    frame_start = 1'b0; last_bit = 1'b0; reg_wr_en = 1'b0; cmd_clr_cnt = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #1 d = reg_rd_data;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    step();
  endtask

  task automatic pulse_last();
    last_bit = 1'b1;
    step();
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'd0, d); chk("R1", d, 32'h0);
    for (int k = 0; k < N; k++) begin rd(4'(k + 1), d); chk("R1", d, 32'h0); end
    chk("R1", {31'b0, wr_err}, 32'h0);
    chk("R1", frame_attr, 32'h0);

    // R2 attribute writes and readback
    for (int k = 0; k < N; k++) begin
      attr_val[k] = 32'hA5000001 + 32'(k) * 32'h01010101;
      wr(4'(k + 1), attr_val[k]);
    end
    for (int k = 0; k < N; k++) begin rd(4'(k + 1), d); chk("R2", d, attr_val[k]); end
    wr(4'(N + 1), 32'hFFFFFFFF);
    rd(4'(N + 1), d); chk("R2", d, 32'h0);

    // R3/R4/R5 selection sweep
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 8; s++) begin
        is_master = m[0]; cmd_sel = 3'(s); frame_start = 1'b1;
        step();
        if (m == 0)      chk("R4", frame_attr, attr_val[0]);
        else if (s >= N) chk("R5", frame_attr, attr_val[0]);
        else             chk("R3", frame_attr, attr_val[s]);
      end
    end

    // R9/R7 preset and layout
    wr(4'd0, 32'h1234FFFF);
    exp_cnt = 16'h1234;
    rd(4'd0, d); chk("R9", d, {exp_cnt, 16'h0});
    chk("R7", {16'h0, d[15:0]}, 32'h0);

    // R8 increments
    for (int i = 0; i < 5; i++) begin
      pulse_last(); exp_cnt = exp_cnt + 16'd1;
      rd(4'd0, d); chk("R8", d, {exp_cnt, 16'h0});
    end
    wr(4'd0, 32'hFFFE0000); exp_cnt = 16'hFFFE;
    for (int i = 0; i < 3; i++) begin
      pulse_last(); exp_cnt = exp_cnt + 16'd1;
      rd(4'd0, d); chk("R8", d, {exp_cnt, 16'h0});
    end

    // R10 clear at frame start
    frame_start = 1'b1; cmd_clr_cnt = 1'b0; step();
    rd(4'd0, d); chk("R10", d, {exp_cnt, 16'h0});
    frame_start = 1'b1; cmd_clr_cnt = 1'b1; step();
    rd(4'd0, d); chk("R10", d, 32'h0);

    // R11 collision of clear and increment
    wr(4'd0, 32'h000A0000);
    frame_start = 1'b1; cmd_clr_cnt = 1'b1; last_bit = 1'b1; step();
    rd(4'd0, d); chk("R11", d, 32'h0);
    pulse_last();
    rd(4'd0, d); chk("R11", d, 32'h00020000);
    pulse_last();
    rd(4'd0, d); chk("R11", d, 32'h00030000);

    // R9 preset discards deferred increment
    frame_start = 1'b1; cmd_clr_cnt = 1'b1; last_bit = 1'b1; step();
    wr(4'd0, 32'h00500000);
    pulse_last();
    rd(4'd0, d); chk("R9", d, 32'h00510000);

    // R6 writes while busy
    busy = 1'b1;
    wr(4'd2, 32'hDEADBEEF);
    rd(4'd2, d); chk("R6", d, attr_val[1]);
    chk("R6", {31'b0, wr_err}, 32'h1);
    wr(4'd0, 32'h77770000);
    rd(4'd0, d); chk("R6", d, 32'h00510000);
    busy = 1'b0;
    step();
    chk("R6", {31'b0, wr_err}, 32'h1);
    wr(4'd1, 32'h0BADF00D);
    rd(4'd1, d); chk("R2", d, 32'h0BADF00D);
    chk("R6", {31'b0, wr_err}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule